// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Critical-Word Bypass

This block sits between a processor's fetch unit and its bus master. The fetch unit presents a word-aligned 32-bit address and holds it until the cache answers with the 32-bit instruction. The cache holds 512 bytes as 32 direct-mapped lines of four words each. A lookup that finds a valid line with a matching tag answers in the same cycle. A lookup that fails asks the bus master for the whole line as a single four-word burst.

While that burst streams in, the cache writes each word into its line. When the word the fetch unit is waiting for arrives, the cache passes it straight from the fill port to the response port in the same cycle it is written. No extra read of the array follows the fill. Once the requested word has been delivered, the fetch unit may move on. A request to any other valid line is answered while the fill continues. A request to the line under fill waits until the fill has finished. An invalidate input drops every line at once.

Top module: `icache_top`

## Requirements
- R1: After reset no line is valid, rsp_valid_o and fill_req_o are low while no request is presented, and the first fetch to any address starts a line fill.
- R2: Address bits [1:0] are ignored. Bits [3:2] select the word within a line, bits [8:4] select one of 32 lines, and bits [31:9] form the tag.
- R3: When the cache is not filling, a request that hits raises rsp_valid_o in the same cycle with the stored word, and no fill is requested.
- R4: A miss raises fill_req_o for exactly one cycle, the cycle the request is presented. fill_addr_o is the request address with bits [3:0] cleared, and one fill request is made per missing line.
- R5: Fill words are taken one per cycle in which fill_valid_i is high, in ascending order: word 0 (address offset 0x0), then 0x4, 0x8 and 0xC. The line becomes valid only after the fourth word has been written.
- R6: The requested word is presented on rsp_data_o with rsp_valid_o high in the same cycle that it arrives on fill_data_i. With first-word latency L, this happens L plus the word offset cycles after the miss.
- R7: After the bypass, a request that maps to the line still being filled gets no response until the fill ends. It hits in the cycle after the fourth word.
- R8: After the bypass, a request that hits a different valid line is answered in the same cycle, while the fill is still in progress.
- R9: A request with the same index but a different tag misses and replaces the line. The old tag then misses again.
- R10: inval_i clears every valid bit in one cycle. A fill that is in progress while inval_i is high completes but leaves its line invalid.
- R11: rsp_valid_o is high only while fetch_req_i is high, and never in the same cycle as fill_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_i | input | 1 | Invalidate all lines |
| fetch_req_i | input | 1 | Fetch request, held until answered |
| fetch_addr_i | input | 32 | Fetch byte address |
| rsp_valid_o | output | 1 | Instruction returned this cycle |
| rsp_data_o | output | 32 | Returned instruction |
| fill_req_o | output | 1 | Line fill request pulse |
| fill_addr_o | output | 32 | Line-aligned fill address |
| fill_valid_i | input | 1 | Fill word present |
| fill_data_i | input | 32 | Fill word |

## Verification
The hardest situation to reach is a second request arriving while a fill is still half done. It takes three steps: a miss whose bypass has already been delivered, a fill that is still streaming, and a follow-up address chosen to land either on the line under fill or on another valid line. The bench reaches it with a bus model that delivers words on back-to-back cycles after a set latency. It issues the next fetch the cycle after the bypass, then compares the number of fill words delivered by response time against four. The same timing is used to pulse the invalidate input during a fill, and a later fetch then proves that the line was left invalid.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic {ST_IDLE, ST_FILL} fill_st_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
    parameter int NUM_LINES = 32,
    parameter int IDX_W     = 5,
    parameter int TAG_W     = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all_i,
    input  logic             clr_one_i,
    input  logic             set_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    input  logic [TAG_W-1:0] rd_tag_i,
    output logic             hit_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0]            valid;
        logic [NUM_LINES-1:0][TAG_W-1:0] tag;
    } tags_s;

    tags_s tags_d, tags_q;

    always_comb begin
        tags_d = tags_q;
        if (clr_one_i) tags_d.valid[wr_idx_i] = 1'b0;
        if (set_i) begin
            tags_d.valid[wr_idx_i] = 1'b1;
            tags_d.tag[wr_idx_i]   = wr_tag_i;
        end
        if (clr_all_i) tags_d.valid = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tags_q <= '0;
        else        tags_q <= tags_d;
    end

    assign hit_o = tags_q.valid[rd_idx_i] && (tags_q.tag[rd_idx_i] == rd_tag_i);

    // R10
    inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (tags_q.valid == '0));
endmodule

// File: rtl/icache_data.sv
module icache_data #(
    parameter int NUM_LINES  = 32,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 5,
    parameter int OFF_W      = 2
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [OFF_W-1:0]  wr_word_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [OFF_W-1:0]  rd_word_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = NUM_LINES * LINE_WORDS;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[{wr_idx_i, wr_word_i}] <= wr_data_i;
    end

    assign rd_data_o = mem_q[{rd_idx_i, rd_word_i}];
endmodule

// File: rtl/icache_fill_ctl.sv
module icache_fill_ctl
    import icache_pkg::*;
#(
    parameter int OFF_W = 2,
    parameter int IDX_W = 5,
    parameter int TAG_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [OFF_W-1:0] req_off_i,
    input  logic [IDX_W-1:0] req_idx_i,
    input  logic [TAG_W-1:0] req_tag_i,
    input  logic             hit_i,
    input  logic             inval_i,
    input  logic             fill_valid_i,
    output logic             fill_req_o,
    output logic             rsp_valid_o,
    output logic             bypass_o,
    output logic             mem_we_o,
    output logic [IDX_W-1:0] fill_idx_o,
    output logic [OFF_W-1:0] fill_word_o,
    output logic             clr_one_o,
    output logic             set_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [TAG_W-1:0] wr_tag_o
);
    localparam logic [OFF_W-1:0] LAST_WORD = '1;

    typedef struct packed {
        fill_st_e         st;
        logic [OFF_W-1:0] cnt;
        logic [OFF_W-1:0] crit;
        logic             sent;
        logic             kill;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        fill_req_o  = 1'b0;
        rsp_valid_o = 1'b0;
        bypass_o    = 1'b0;
        mem_we_o    = 1'b0;
        clr_one_o   = 1'b0;
        set_o       = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_i && hit_i) begin
                    rsp_valid_o = 1'b1;
                end else if (req_i) begin
                    fill_req_o = 1'b1;
                    clr_one_o  = 1'b1;
                    ctl_d.st   = ST_FILL;
                    ctl_d.cnt  = '0;
                    ctl_d.crit = req_off_i;
                    ctl_d.sent = 1'b0;
                    ctl_d.kill = 1'b0;
                    ctl_d.idx  = req_idx_i;
                    ctl_d.tag  = req_tag_i;
                end
            end
            ST_FILL: begin
                ctl_d.kill = ctl_q.kill | inval_i;
                if (ctl_q.sent && req_i && hit_i && (req_idx_i != ctl_q.idx))
                    rsp_valid_o = 1'b1;
                if (fill_valid_i) begin
                    mem_we_o  = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (!ctl_q.sent && req_i && (ctl_q.cnt == ctl_q.crit)) begin
                        rsp_valid_o = 1'b1;
                        bypass_o    = 1'b1;
                        ctl_d.sent  = 1'b1;
                    end
                    if (ctl_q.cnt == LAST_WORD) begin
                        ctl_d.st = ST_IDLE;
                        set_o    = !(ctl_q.kill || inval_i);
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign fill_idx_o  = ctl_q.idx;
    assign fill_word_o = ctl_q.cnt;
    assign wr_idx_o    = (ctl_q.st == ST_IDLE) ? req_idx_i : ctl_q.idx;
    assign wr_tag_o    = ctl_q.tag;

    // R4
    fill_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_o |=> !fill_req_o);
    // R7
    stall_same_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FILL && ctl_q.sent && req_i && req_idx_i == ctl_q.idx) |-> !rsp_valid_o);
    // R11
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> req_i);
    // R11
    rsp_not_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid_o && fill_req_o));
    // R5
    set_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |=> (ctl_q.st == ST_IDLE));
endmodule

// File: rtl/icache_top.sv
module icache_top #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval_i,
    input  logic              fetch_req_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              fill_req_o,
    output logic [ADDR_W-1:0] fill_addr_o,
    input  logic              fill_valid_i,
    input  logic [DATA_W-1:0] fill_data_i
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int LO_W   = BYTE_W + OFF_W;
    localparam int TAG_W  = ADDR_W - IDX_W - LO_W;

    logic [OFF_W-1:0]  req_off;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              addr_lo_unused;
    logic              hit, bypass, mem_we, clr_one, set_line;
    logic [IDX_W-1:0]  fill_idx, wr_idx;
    logic [OFF_W-1:0]  fill_word;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] rd_data;

    assign req_off        = fetch_addr_i[BYTE_W +: OFF_W];
    assign req_idx        = fetch_addr_i[LO_W +: IDX_W];
    assign req_tag        = fetch_addr_i[ADDR_W-1 -: TAG_W];
    assign addr_lo_unused = ^fetch_addr_i[BYTE_W-1:0];
    assign fill_addr_o    = {req_tag, req_idx, {LO_W{1'b0}}};
    assign rsp_data_o     = bypass ? fill_data_i : rd_data;

    icache_tags #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .clr_all_i(inval_i), .clr_one_i(clr_one),
        .set_i(set_line), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag),
        .rd_idx_i(req_idx), .rd_tag_i(req_tag), .hit_o(hit)
    );

    icache_data #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W),
                  .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
        .clk(clk), .we_i(mem_we), .wr_idx_i(fill_idx), .wr_word_i(fill_word),
        .wr_data_i(fill_data_i), .rd_idx_i(req_idx), .rd_word_i(req_off),
        .rd_data_o(rd_data)
    );

    icache_fill_ctl #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .req_i(fetch_req_i), .req_off_i(req_off),
        .req_idx_i(req_idx), .req_tag_i(req_tag), .hit_i(hit), .inval_i(inval_i),
        .fill_valid_i(fill_valid_i), .fill_req_o(fill_req_o), .rsp_valid_o(rsp_valid_o),
        .bypass_o(bypass), .mem_we_o(mem_we), .fill_idx_o(fill_idx),
        .fill_word_o(fill_word), .clr_one_o(clr_one), .set_o(set_line),
        .wr_idx_o(wr_idx), .wr_tag_o(wr_tag)
    );

    // R6
    bypass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (fill_valid_i && rsp_valid_o && rsp_data_o == fill_data_i));
endmodule

// File: tb/icache_top_tb.sv
module icache_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inval = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int errors = 0;
    int checks = 0;
    int lat = 1;
    int fill_cnt = 0;
    int words = 0;
    int words_at_rsp = 0;
    logic busy = 1'b0;
    logic [31:0] last_fill = '0;

    always #2.5 clk = ~clk;

    icache_top u_dut (
        .clk(clk), .rst_n(rst_n), .inval_i(inval), .fetch_req_i(fetch_req),
        .fetch_addr_i(fetch_addr), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .fill_req_o(fill_req), .fill_addr_o(fill_addr), .fill_valid_i(fill_valid),
        .fill_data_i(fill_data)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) + 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // bus master model: four words, ascending, after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && fill_req) begin
                fill_cnt++;
                last_fill = fill_addr;
                busy = 1'b1;
                words = 0;
                repeat (lat) @(negedge clk);
                for (int k = 0; k < 4; k++) begin
                    fill_valid = 1'b1;
                    fill_data  = word_of(last_fill + 32'(k * 4));
                    words      = k + 1;
                    @(negedge clk);
                end
                fill_valid = 1'b0;
                busy = 1'b0;
            end
        end
    end

    task automatic fetch(input logic [31:0] a, output logic [31:0] d, output int cyc);
        fetch_req  = 1'b1;
        fetch_addr = a;
        cyc = 0;
        d = 32'hDEAD_DEAD;
        forever begin
            #1;
            if (rsp_valid) begin
                d = rsp_data;
                words_at_rsp = words;
                break;
            end
            if (cyc >= 100) break;
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_inval();
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
        chk("R1 fill_req in reset", 32'(fill_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R11 no rsp without req", 32'(rsp_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_miss_bypass();
        logic [31:0] d; int c; int f0;
        lat = 2; f0 = fill_cnt;
        fetch(32'h0000_1040, d, c);
        chk("R1 first fetch fills", 32'(fill_cnt - f0), 1);
        chk("R4 fill address", last_fill, 32'h0000_1040);
        chk("R6 bypass cycle", 32'(c), 2);
        chk("R6 bypass data", d, word_of(32'h0000_1040));
        wait_idle();
    endtask

    task automatic t_hit();
        logic [31:0] d; int c; int f0;
        f0 = fill_cnt;
        fetch(32'h0000_1048, d, c);
        chk("R3 hit latency", 32'(c), 0);
        chk("R3 hit data", d, word_of(32'h0000_1048));
        fetch(32'h0000_104C, d, c);
        chk("R5 word3 stored", d, word_of(32'h0000_104C));
        chk("R3 no fill on hit", 32'(fill_cnt - f0), 0);
    endtask

    task automatic t_align();
        logic [31:0] d; int c;
        lat = 1;
        fetch(32'h0000_207E, d, c);
        chk("R2 fill addr aligned", last_fill, 32'h0000_2070);
        chk("R6 bypass last word cycle", 32'(c), 4);
        chk("R2 low bits ignored", d, word_of(32'h0000_207C));
        wait_idle();
        fetch(32'h0000_2071, d, c);
        chk("R5 word0 stored", d, word_of(32'h0000_2070));
        chk("R2 hit with low bits", 32'(c), 0);
    endtask

    task automatic t_stall();
        logic [31:0] d; int c; int f0;
        lat = 1; f0 = fill_cnt;
        fetch(32'h0000_3000, d, c);
        fetch(32'h0000_3004, d, c);
        chk("R7 stall until fill done", 32'(words_at_rsp), 4);
        chk("R7 data after stall", d, word_of(32'h0000_3004));
        chk("R4 one fill per line", 32'(fill_cnt - f0), 1);
        wait_idle();
    endtask

    task automatic t_hit_during_fill();
        logic [31:0] d; int c;
        lat = 1;
        fetch(32'h0000_4050, d, c);
        fetch(32'h0000_1044, d, c);
        chk("R8 hit during fill cycle", 32'(c), 0);
        chk("R8 fill still running", 32'(words_at_rsp < 4), 1);
        chk("R8 hit during fill data", d, word_of(32'h0000_1044));
        wait_idle();
    endtask

    task automatic t_conflict();
        logic [31:0] d; int c; int f0;
        f0 = fill_cnt;
        fetch(32'h0000_1240, d, c);
        wait_idle();
        chk("R9 same index new tag misses", 32'(fill_cnt - f0), 1);
        chk("R9 new tag data", d, word_of(32'h0000_1240));
        fetch(32'h0000_1040, d, c);
        wait_idle();
        chk("R9 old tag evicted", 32'(fill_cnt - f0), 2);
    endtask

    task automatic t_inval();
        logic [31:0] d; int c; int f0;
        f0 = fill_cnt;
        fetch(32'h0000_1040, d, c);
        chk("R10 hit before inval", 32'(fill_cnt - f0), 0);
        pulse_inval();
        fetch(32'h0000_1040, d, c);
        wait_idle();
        chk("R10 miss after inval", 32'(fill_cnt - f0), 1);
    endtask

    task automatic t_inval_fill();
        logic [31:0] d; int c; int f0;
        lat = 1; f0 = fill_cnt;
        fetch(32'h0000_5090, d, c);
        pulse_inval();
        wait_idle();
        fetch(32'h0000_5094, d, c);
        wait_idle();
        chk("R10 fill killed by inval", 32'(fill_cnt - f0), 2);
        chk("R10 refetch data", d, word_of(32'h0000_5094));
    endtask

    task automatic t_edge();
        logic [31:0] d; int c;
        lat = 3;
        fetch(32'hFFFF_FFFC, d, c);
        chk("R2 top line fill addr", last_fill, 32'hFFFF_FFF0);
        chk("R6 top line bypass cycle", 32'(c), 6);
        wait_idle();
        fetch(32'hFFFF_FFF4, d, c);
        chk("R2 top line hit", 32'(c), 0);
        chk("R2 top line data", d, word_of(32'hFFFF_FFF4));
        fetch(32'h0000_000C, d, c);
        chk("R2 line zero data", d, word_of(32'h0000_000C));
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_miss_bypass();
        t_hit();
        t_align();
        t_stall();
        t_hit_during_fill();
        t_conflict();
        t_inval();
        t_inval_fill();
        t_edge();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule